// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port static memory. It has a left port and a right port, and each port has its own clock. Each port has an address, a write-data bus, a registered read-data bus, a read/write select, one byte select per 9-bit lane, and two chip selects of opposite polarity. Both ports may touch any location in the same cycle. Read data passes through an output register, so a read captured on one clock edge shows up just after that edge and stays until the next enabled read of that lane.

The two highest addresses also act as message mailboxes between the ports. A port that writes into the other port's mailbox pulls that port's active-low interrupt low. The interrupt returns high once its owner reads its own mailbox. An asynchronous, active-low master reset releases both interrupts and clears both read registers. Memory contents are left as they were.

A deselected port does nothing. The port is deselected when its low-active select is high or its high-active select is low. One clock with both selects active is enough to bring fresh read data back.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: A write (rw = 0) on a selected port stores the write data on that port's clock edge, and either port can read it back from the next cycle on.
- R2: A read (rw = 1) on a selected port drives the addressed word on rdata just after the capturing clock edge. The word stays there until the next enabled read.
- R3: On a write, byte select bit 0 enables data bits 8:0 and bit 1 enables bits 17:9. A lane whose select is 0 keeps its stored contents.
- R4: On a read, a lane whose byte select is 0 keeps its previous rdata value, and an enabled lane is updated.
- R5: A port with cs_n = 1 or cs = 0 ignores writes and holds its rdata unchanged.
- R6: After any number of deselected cycles, a single selected read cycle delivers valid data on rdata after that one edge.
- R7: Both ports work at the same time on different addresses. A read by one port of an address that the other port writes in the same cycle returns the contents from before that write. Two writes to one address in the same cycle give an undefined result.
- R8: The all-ones address is the left mailbox. A selected write there from the right port, with any byte selects, drives l_irq_n low after that edge.
- R9: The all-ones-minus-one address is the right mailbox. A selected write there from the left port drives r_irq_n low after that edge.
- R10: An interrupt returns high after its owner's selected read of its own mailbox. A read of that mailbox by the other port does not clear it, and a write by the owner into its own mailbox does not raise it.
- R11: While mrst_n is low, at once and without a clock, both irq outputs are high and both rdata buses are zero. Stored words survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_cs | input | 1 | Left chip select, active high |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_bsel | input | 2 | Left byte selects (bit 0: data 8:0, bit 1: data 17:9) |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_cs | input | 1 | Right chip select, active high |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_bsel | input | 2 | Right byte selects |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Words written from one port and read from the other show that both ports see the same storage. Partial-lane writes and reads with patterns whose two halves differ show whether a lane that is turned off really keeps its old value. Writes and reads issued while either chip select is inactive expose a deselect that is decoded with the wrong polarity. A same-cycle write and read of one address separates old-data from new-data read ordering. The mailbox sequences set and clear each interrupt from each side, including the other port's reads and the owner's own writes. These tell a correct owner mapping apart from a swapped one.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } rw_e;

  function automatic logic port_active(input logic cs_low, input logic cs_high);
    return (!cs_low) && cs_high;
  endfunction
endpackage

// File: rtl/dpm_lane_store.sv
// One byte lane of storage with two write ports. Each port owns a bank and a
// tag bit per word; the XOR of the two tags says which bank holds the newer word.
module dpm_lane_store #(
  parameter int AW = 10,
  parameter int LW = 9
) (
  input  logic          clk_a,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [LW-1:0] a_wd,
  output logic [LW-1:0] a_rd,
  input  logic          clk_b,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [LW-1:0] b_wd,
  output logic [LW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] bank_a [DEPTH];
  logic [LW-1:0] bank_b [DEPTH];
  logic          tag_a  [DEPTH];
  logic          tag_b  [DEPTH];

  always_ff @(posedge clk_a) begin
    if (a_we) begin
      bank_a[a_addr] <= a_wd;
      tag_a[a_addr]  <= ~tag_b[a_addr];
    end
  end

  always_ff @(posedge clk_b) begin
    if (b_we) begin
      bank_b[b_addr] <= b_wd;
      tag_b[b_addr]  <= tag_a[b_addr];
    end
  end

  assign a_rd = (tag_a[a_addr] ^ tag_b[a_addr]) ? bank_a[a_addr] : bank_b[a_addr];
  assign b_rd = (tag_a[b_addr] ^ tag_b[b_addr]) ? bank_a[b_addr] : bank_b[b_addr];
endmodule

// File: rtl/dpm_read_reg.sv
module dpm_read_reg #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd_req,
  input  logic [LANES-1:0] bsel,
  input  logic [DW-1:0]    mem_rd,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata[g*LANE_W +: LANE_W] <= '0;
      else if (rd_req && bsel[g])
        rdata[g*LANE_W +: LANE_W] <= mem_rd[g*LANE_W +: LANE_W];
    end

    // R4: an unselected lane keeps its read value
    assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !bsel[g]) |=> $stable(rdata[g*LANE_W +: LANE_W]));
  end

  // R5: a deselected port holds its output register
  assert_desel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(rdata));
endmodule

// File: rtl/dpm_mbox_flag.sv
// Interrupt flag set from the writer's clock and cleared from the owner's clock.
// Each side owns one toggle bit, and the flag is active while the two differ.
module dpm_mbox_flag (
  input  logic set_clk,
  input  logic clr_clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_n
);
  logic set_tog;
  logic clr_tog;

  always_ff @(posedge set_clk or negedge rst_n) begin
    if (!rst_n)      set_tog <= 1'b0;
    else if (set_ev) set_tog <= ~clr_tog;
  end

  always_ff @(posedge clr_clk or negedge rst_n) begin
    if (!rst_n)      clr_tog <= 1'b0;
    else if (clr_ev) clr_tog <= set_tog;
  end

  assign irq_n = ~(set_tog ^ clr_tog);

  // R8 / R9: a write into the mailbox raises the owner's interrupt
  assert_irq_raise_R8: assert property (@(posedge set_clk) disable iff (!rst_n)
    (set_ev && !clr_ev) |=> !irq_n);

  // R10: the owner's read of its mailbox releases the interrupt
  assert_irq_clear_R10: assert property (@(posedge clr_clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> irq_n);
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              mrst_n,
  input  logic              l_cs_n,
  input  logic              l_cs,
  input  logic              l_rw,
  input  logic [LANES-1:0]  l_bsel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_cs,
  input  logic              r_rw,
  input  logic [LANES-1:0]  r_bsel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] MBOX_L = '1;
  localparam logic [ADDR_W-1:0] MBOX_R = MBOX_L - 1'b1;

  logic l_sel, r_sel, l_wr, r_wr, l_rdq, r_rdq;
  logic [DATA_W-1:0] l_mem_rd, r_mem_rd;

  assign l_sel = port_active(l_cs_n, l_cs);
  assign r_sel = port_active(r_cs_n, r_cs);
  assign l_wr  = l_sel && (rw_e'(l_rw) == OP_WRITE);
  assign r_wr  = r_sel && (rw_e'(r_rw) == OP_WRITE);
  assign l_rdq = l_sel && (rw_e'(l_rw) == OP_READ);
  assign r_rdq = r_sel && (rw_e'(r_rw) == OP_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_store
    dpm_lane_store #(.AW(ADDR_W), .LW(LANE_W)) u_store (
      .clk_a (clk_l),
      .a_we  (l_wr && l_bsel[g]),
      .a_addr(l_addr),
      .a_wd  (l_wdata[g*LANE_W +: LANE_W]),
      .a_rd  (l_mem_rd[g*LANE_W +: LANE_W]),
      .clk_b (clk_r),
      .b_we  (r_wr && r_bsel[g]),
      .b_addr(r_addr),
      .b_wd  (r_wdata[g*LANE_W +: LANE_W]),
      .b_rd  (r_mem_rd[g*LANE_W +: LANE_W])
    );
  end

  dpm_read_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_lreg (
    .clk(clk_l), .rst_n(mrst_n), .sel(l_sel), .rd_req(l_rdq),
    .bsel(l_bsel), .mem_rd(l_mem_rd), .rdata(l_rdata)
  );

  dpm_read_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_rreg (
    .clk(clk_r), .rst_n(mrst_n), .sel(r_sel), .rd_req(r_rdq),
    .bsel(r_bsel), .mem_rd(r_mem_rd), .rdata(r_rdata)
  );

  // left mailbox: written by the right port, read by the left port
  dpm_mbox_flag u_lflag (
    .set_clk(clk_r), .clr_clk(clk_l), .rst_n(mrst_n),
    .set_ev (r_wr  && (r_addr == MBOX_L)),
    .clr_ev (l_rdq && (l_addr == MBOX_L)),
    .irq_n  (l_irq_n)
  );

  // right mailbox: written by the left port, read by the right port
  dpm_mbox_flag u_rflag (
    .set_clk(clk_l), .clr_clk(clk_r), .rst_n(mrst_n),
    .set_ev (l_wr  && (l_addr == MBOX_R)),
    .clr_ev (r_rdq && (r_addr == MBOX_R)),
    .irq_n  (r_irq_n)
  );

  // R1: a full-word write from the left port is what storage returns next cycle
  assert_write_lands_R1: assert property (@(posedge clk_l) disable iff (!mrst_n)
    (l_wr && (&l_bsel) && !(r_wr && (r_addr == l_addr))) ##1 (l_addr == $past(l_addr))
    |-> (l_mem_rd == $past(l_wdata)));
endmodule

// File: tb/dpm_mailbox_ram_tb.sv
module dpm_mailbox_ram_tb;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [AW-1:0] MB_L = 10'h3FF;
  localparam logic [AW-1:0] MB_R = 10'h3FE;

  logic clk = 1'b0;
  logic mrst_n = 1'b1;
  logic l_cs_n, l_cs, l_rw, r_cs_n, r_cs, r_rw;
  logic [1:0] l_bsel, r_bsel;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dpm_mailbox_ram u_dut (
    .clk_l(clk), .clk_r(clk), .mrst_n(mrst_n),
    .l_cs_n(l_cs_n), .l_cs(l_cs), .l_rw(l_rw), .l_bsel(l_bsel),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_cs(r_cs), .r_rw(r_rw), .r_bsel(r_bsel),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lp(input logic cs_n, input logic cs, input logic rw,
                    input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] b);
    l_cs_n = cs_n; l_cs = cs; l_rw = rw; l_addr = a; l_wdata = d; l_bsel = b;
  endtask

  task automatic rp(input logic cs_n, input logic cs, input logic rw,
                    input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] b);
    r_cs_n = cs_n; r_cs = cs; r_rw = rw; r_addr = a; r_wdata = d; r_bsel = b;
  endtask

  task automatic idle();
    lp(1'b1, 1'b1, 1'b1, '0, '0, 2'b11);
    rp(1'b1, 1'b1, 1'b1, '0, '0, 2'b11);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset l_rdata", l_rdata, '0);
    chk("R11 reset r_rdata", r_rdata, '0);
    chk("R11 reset l_irq_n", DW'(l_irq_n), DW'(1));
    chk("R11 reset r_irq_n", DW'(r_irq_n), DW'(1));
  endtask

  task automatic t_basic();
    lp(1'b0, 1'b1, 1'b0, 10'h010, 18'h2A5A5, 2'b11); step(); idle();
    rp(1'b0, 1'b1, 1'b1, 10'h010, '0, 2'b11);
    lp(1'b0, 1'b1, 1'b1, 10'h010, '0, 2'b11); step(); idle();
    chk("R1 cross-port readback", r_rdata, 18'h2A5A5);
    chk("R2 same-port read", l_rdata, 18'h2A5A5);
    step();
    chk("R2 rdata held with no read", r_rdata, 18'h2A5A5);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] d = 18'h12345;
    lp(1'b0, 1'b1, 1'b0, 10'h020, d, 2'b11); step();
    lp(1'b0, 1'b1, 1'b0, 10'h020, 18'h3FFFF, 2'b10); step();
    lp(1'b0, 1'b1, 1'b1, 10'h020, '0, 2'b11); step(); idle();
    chk("R3 upper lane written, lower kept", l_rdata, {9'h1FF, d[8:0]});
    lp(1'b0, 1'b1, 1'b0, 10'h020, 18'h0, 2'b01); step();
    lp(1'b0, 1'b1, 1'b1, 10'h020, '0, 2'b11); step(); idle();
    chk("R3 lower lane written, upper kept", l_rdata, {9'h1FF, 9'h000});
  endtask

  task automatic t_read_bsel();
    logic [DW-1:0] v = 18'h0AB56;
    lp(1'b0, 1'b1, 1'b0, 10'h030, v, 2'b11); step();
    rp(1'b0, 1'b1, 1'b1, 10'h020, '0, 2'b11); lp(1'b1, 1'b1, 1'b1, '0, '0, 2'b11); step();
    rp(1'b0, 1'b1, 1'b1, 10'h030, '0, 2'b01); step(); idle();
    chk("R4 read lower lane only", r_rdata, {9'h1FF, v[8:0]});
    rp(1'b0, 1'b1, 1'b1, 10'h030, '0, 2'b10); step(); idle();
    chk("R4 read upper lane only", r_rdata, v);
  endtask

  task automatic t_deselect();
    lp(1'b0, 1'b1, 1'b0, 10'h040, 18'h1C3C3, 2'b11); step();
    lp(1'b1, 1'b1, 1'b0, 10'h040, 18'h00F0F, 2'b11); step();
    lp(1'b0, 1'b0, 1'b0, 10'h040, 18'h00F0F, 2'b11); step();
    rp(1'b0, 1'b0, 1'b1, 10'h010, '0, 2'b11); step();
    chk("R5 cs low: rdata held", r_rdata, 18'h0AB56);
    rp(1'b1, 1'b1, 1'b1, 10'h010, '0, 2'b11); step(); idle();
    chk("R5 cs_n high: rdata held", r_rdata, 18'h0AB56);
    step(); step();
    rp(1'b0, 1'b1, 1'b1, 10'h040, '0, 2'b11); step(); idle();
    chk("R5 deselected writes ignored", r_rdata, 18'h1C3C3);
    chk("R6 one selected cycle restores data", r_rdata, 18'h1C3C3);
  endtask

  task automatic t_dual();
    lp(1'b0, 1'b1, 1'b0, 10'h050, 18'h11111, 2'b11);
    rp(1'b0, 1'b1, 1'b0, 10'h051, 18'h22222, 2'b11); step();
    lp(1'b0, 1'b1, 1'b1, 10'h051, '0, 2'b11);
    rp(1'b0, 1'b1, 1'b1, 10'h050, '0, 2'b11); step(); idle();
    chk("R7 left reads right's word", l_rdata, 18'h22222);
    chk("R7 right reads left's word", r_rdata, 18'h11111);
    lp(1'b0, 1'b1, 1'b0, 10'h050, 18'h33333, 2'b11);
    rp(1'b0, 1'b1, 1'b1, 10'h050, '0, 2'b11); step(); idle();
    chk("R7 same-cycle read returns old word", r_rdata, 18'h11111);
    rp(1'b0, 1'b1, 1'b1, 10'h050, '0, 2'b11); step(); idle();
    chk("R7 next read returns new word", r_rdata, 18'h33333);
  endtask

  task automatic t_mbox_left();
    rp(1'b0, 1'b1, 1'b0, MB_L, 18'h0BEEF, 2'b01); step(); idle();
    chk("R8 right write raises l_irq_n", DW'(l_irq_n), DW'(0));
    chk("R8 r_irq_n untouched", DW'(r_irq_n), DW'(1));
    rp(1'b0, 1'b1, 1'b1, MB_L, '0, 2'b11); step(); idle();
    chk("R10 other port's read keeps l_irq_n", DW'(l_irq_n), DW'(0));
    lp(1'b0, 1'b1, 1'b1, MB_L, '0, 2'b11); step(); idle();
    chk("R10 owner read clears l_irq_n", DW'(l_irq_n), DW'(1));
    chk("R8 message readable", l_rdata[8:0], 9'h0EF);
  endtask

  task automatic t_mbox_right();
    lp(1'b0, 1'b1, 1'b0, MB_R, 18'h00123, 2'b11); step(); idle();
    chk("R9 left write raises r_irq_n", DW'(r_irq_n), DW'(0));
    chk("R9 l_irq_n untouched", DW'(l_irq_n), DW'(1));
    lp(1'b0, 1'b1, 1'b0, MB_L, 18'h00777, 2'b11); step(); idle();
    chk("R10 owner write to own mailbox no irq", DW'(l_irq_n), DW'(1));
    rp(1'b0, 1'b1, 1'b1, MB_R, '0, 2'b11); step(); idle();
    chk("R10 owner read clears r_irq_n", DW'(r_irq_n), DW'(1));
    chk("R9 message readable", r_rdata, 18'h00123);
  endtask

  task automatic t_mrst();
    rp(1'b0, 1'b1, 1'b0, MB_L, 18'h00055, 2'b11); step(); idle();
    chk("R11 pre-reset irq set", DW'(l_irq_n), DW'(0));
    #2 mrst_n = 1'b0;
    #1;
    chk("R11 async reset l_irq_n", DW'(l_irq_n), DW'(1));
    chk("R11 async reset l_rdata", l_rdata, '0);
    chk("R11 async reset r_rdata", r_rdata, '0);
    step(); mrst_n = 1'b1; step();
    lp(1'b0, 1'b1, 1'b1, 10'h010, '0, 2'b11); step(); idle();
    chk("R11 memory kept across reset", l_rdata, 18'h2A5A5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    #1 mrst_n = 1'b0;
    repeat (3) step();
    mrst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_bytes();
    t_read_bsel();
    t_deselect();
    t_dual();
    t_mbox_left();
    t_mbox_right();
    t_mrst();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule